// File: doc/BRIEF.md
# Translation Entry Matcher with Excluded Low Region

This block decides whether a single translation-buffer entry covers an incoming virtual page number. The entry presents its stored page number, a page-size code, a valid flag, a process tag, a partition tag and an exclusion flag. The request presents its page number, process tag and partition tag. The block ignores the page-number bits that lie inside the entry's page offset, compares the rest, checks both tags, and returns a single hit bit one clock later.

When the exclusion flag is set, part of a large page is cut out, starting at the page's base. The stored page number has low bits that fall inside the page offset and would otherwise go unused. These bits describe the excluded region. A request is rejected when its in-page bits set no bit that the entry leaves clear. If the entry's low in-page bits are a run of ones of length h, the lowest 2^h small pages are excluded. For example, a 1 MB page can give up its lowest 64 KB and keep 960 KB mapped.

One instance serves one entry. An array of entries places one instance beside each stored entry and combines the hit bits outside this block.

Top module: `tlbm_entry_match`

## Requirements
- R1: `hit` is 0 while `rst_n` is low, and it shows the match result of the inputs present at a rising clock edge only after that edge, so the latency is one cycle.
- R2: An entry with `entry_valid` = 0 never hits.
- R3: Page numbers count 4 KB units, with bit 0 the lowest. The size codes are 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB, 4 = 256 MB and 5 = 1 GB. These codes ignore page-number bits below positions 0, 4, 8, 12, 16 and 18 respectively. All higher bits must be equal for a hit.
- R4: Size codes 6 and 7 never hit.
- R5: An entry process tag of zero matches any request process tag. Any other entry process tag must equal the request process tag exactly.
- R6: The request partition tag must equal the entry partition tag.
- R7: With the exclusion flag set and a size code from 1 to 5, a request misses unless at least one of its ignored in-page bits is 1 where the entry's stored bit is 0.
- R8: The exclusion flag has no effect on 4 KB entries. A clear exclusion flag never blocks a hit.
- R9: For a 1 MB entry with the exclusion flag set and low stored bits 7..0 = 0x0F, requests with bits 7..0 from 0x00 to 0x0F miss, and requests with bits 7..0 from 0x10 to 0xFF hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the result register |
| entry_valid | input | 1 | Entry holds a live translation |
| entry_size | input | 3 | Page-size code of the entry |
| entry_xbit | input | 1 | Exclusion flag: low region of the page is not mapped |
| entry_vpn | input | VPN_W | Stored page number, low in-page bits give the excluded region |
| entry_pid | input | PID_W | Entry process tag, zero is a wildcard |
| entry_lpid | input | LPID_W | Entry partition tag |
| req_vpn | input | VPN_W | Requested page number |
| req_pid | input | PID_W | Request process tag |
| req_lpid | input | LPID_W | Request partition tag |
| hit | output | 1 | Registered match result |

## Verification
The assertions assume that the inputs are stable and defined at every rising edge after reset. They also assume that each registered hit can be traced to the inputs of the previous edge, because every property relates `hit` to the one-cycle-old request and entry fields. The bench meets this by changing every input only on the falling edge and holding it for a whole cycle. It also drives every field, including the invalid size codes, from the first cycle of reset onward, so no property sees an undriven value.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    localparam int unsigned NUM_SIZES  = 6;
    localparam int unsigned NUM_GROUPS = NUM_SIZES - 1;
    localparam int unsigned CODE_W     = 3;
    localparam int unsigned NUM_CODES  = 1 << CODE_W;

    typedef enum logic [CODE_W-1:0] {
        PG_4K   = 3'd0,
        PG_64K  = 3'd1,
        PG_1M   = 3'd2,
        PG_16M  = 3'd3,
        PG_256M = 3'd4,
        PG_1G   = 3'd5
    } pg_size_e;

    // Number of page-number bits (4 KB units) that fall inside the offset
    function automatic int unsigned pg_shift(int unsigned code);
        case (code)
            0:       return 0;
            1:       return 4;
            2:       return 8;
            3:       return 12;
            4:       return 16;
            default: return 18;
        endcase
    endfunction

    localparam int unsigned TOP_SHIFT = pg_shift(NUM_SIZES - 1);

    typedef struct packed {
        logic hit;
    } match_state_t;

endpackage

// File: rtl/tlbm_page_cmp.sv
module tlbm_page_cmp
    import tlbm_pkg::*;
#(
    parameter int unsigned VPN_W = 52
) (
    input  logic [VPN_W-1:0]  entry_vpn,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [CODE_W-1:0] size_code,
    output logic              vpn_eq
);
    logic [NUM_GROUPS-1:0] grp_eq;
    logic                  upper_eq;

    // Bits above the largest page offset are always compared
    assign upper_eq = (entry_vpn[VPN_W-1:TOP_SHIFT] == req_vpn[VPN_W-1:TOP_SHIFT]);

    // Group g lies inside the offset once the size code exceeds g
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int unsigned LO = pg_shift(g);
        localparam int unsigned HI = pg_shift(g + 1) - 1;
        localparam logic [CODE_W-1:0] GCODE = CODE_W'(g);
        assign grp_eq[g] = (size_code > GCODE) || (entry_vpn[HI:LO] == req_vpn[HI:LO]);
    end

    assign vpn_eq = upper_eq & (&grp_eq);

endmodule

// File: rtl/tlbm_hole_chk.sv
module tlbm_hole_chk
    import tlbm_pkg::*;
(
    input  logic [TOP_SHIFT-1:0] entry_low,
    input  logic [TOP_SHIFT-1:0] req_low,
    input  logic [CODE_W-1:0]    size_code,
    input  logic                 xbit,
    output logic                 hole_ok
);
    logic [NUM_CODES-1:0] ok_vec;

    // A 4 KB page has no in-page page-number bits, so nothing can be cut out
    assign ok_vec[0] = 1'b1;

    for (genvar s = 1; s < NUM_SIZES; s++) begin : g_size
        localparam int unsigned HI = pg_shift(s) - 1;
        assign ok_vec[s] = |(req_low[HI:0] & ~entry_low[HI:0]);
    end

    for (genvar s = NUM_SIZES; s < NUM_CODES; s++) begin : g_unused
        assign ok_vec[s] = 1'b0;
    end

    assign hole_ok = ~xbit | ok_vec[size_code];

    // R8: small pages and entries without exclusion are never blocked here
    always_comb begin
        if (!xbit || size_code == PG_4K) begin
            p_no_hole_effect_r8: assert (hole_ok);
        end
    end

endmodule

// File: rtl/tlbm_id_cmp.sv
module tlbm_id_cmp #(
    parameter int unsigned PID_W  = 14,
    parameter int unsigned LPID_W = 8
) (
    input  logic [PID_W-1:0]  entry_pid,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [LPID_W-1:0] entry_lpid,
    input  logic [LPID_W-1:0] req_lpid,
    output logic              ids_ok
);
    logic pid_any;
    logic pid_eq;
    logic lpid_eq;

    assign pid_any = (entry_pid == '0);
    assign pid_eq  = (entry_pid == req_pid);
    assign lpid_eq = (entry_lpid == req_lpid);
    assign ids_ok  = (pid_any | pid_eq) & lpid_eq;

endmodule

// File: rtl/tlbm_entry_match.sv
module tlbm_entry_match
    import tlbm_pkg::*;
#(
    parameter int unsigned VPN_W  = 52,
    parameter int unsigned PID_W  = 14,
    parameter int unsigned LPID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_valid,
    input  logic [2:0]        entry_size,
    input  logic              entry_xbit,
    input  logic [VPN_W-1:0]  entry_vpn,
    input  logic [PID_W-1:0]  entry_pid,
    input  logic [LPID_W-1:0] entry_lpid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [LPID_W-1:0] req_lpid,
    output logic              hit
);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_SIZES - 1);

    logic vpn_eq;
    logic hole_ok;
    logic ids_ok;
    logic size_ok;

    match_state_t st_d, st_q;

    tlbm_page_cmp #(.VPN_W(VPN_W)) u_page_cmp (
        .entry_vpn (entry_vpn),
        .req_vpn   (req_vpn),
        .size_code (entry_size),
        .vpn_eq    (vpn_eq)
    );

    tlbm_hole_chk u_hole_chk (
        .entry_low (entry_vpn[TOP_SHIFT-1:0]),
        .req_low   (req_vpn[TOP_SHIFT-1:0]),
        .size_code (entry_size),
        .xbit      (entry_xbit),
        .hole_ok   (hole_ok)
    );

    tlbm_id_cmp #(.PID_W(PID_W), .LPID_W(LPID_W)) u_id_cmp (
        .entry_pid  (entry_pid),
        .req_pid    (req_pid),
        .entry_lpid (entry_lpid),
        .req_lpid   (req_lpid),
        .ids_ok     (ids_ok)
    );

    assign size_ok = (entry_size <= MAX_CODE);

    always_comb begin
        st_d     = st_q;
        st_d.hit = entry_valid & size_ok & vpn_eq & hole_ok & ids_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit = st_q.hit;

    // R2: a hit always comes from a live entry
    p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(entry_valid));

    // R4: undefined size codes never produce a hit
    p_no_bad_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(entry_size) <= MAX_CODE));

    // R3: bits above every page offset agreed on the sampled request
    p_upper_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(entry_vpn[VPN_W-1:TOP_SHIFT]) == $past(req_vpn[VPN_W-1:TOP_SHIFT])));

    // R5: process tag was a wildcard or an exact match
    p_pid_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(entry_pid) == '0 || $past(entry_pid) == $past(req_pid)));

    // R6: partition tags agreed
    p_lpid_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(entry_lpid) == $past(req_lpid)));

    // R7: a 1 MB excluded request never hits
    p_hole_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(entry_xbit) && $past(entry_size) == PG_1M &&
         (($past(req_vpn[7:0]) & ~$past(entry_vpn[7:0])) == 8'h00)) |-> !hit);

endmodule

// File: tb/tb_tlbm_entry_match.sv
module tb_tlbm_entry_match;
    localparam int CLK_PERIOD = 10;
    localparam int VPN_W  = 52;
    localparam int PID_W  = 14;
    localparam int LPID_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              entry_valid = 1'b0;
    logic [2:0]        entry_size = '0;
    logic              entry_xbit = 1'b0;
    logic [VPN_W-1:0]  entry_vpn = '0;
    logic [PID_W-1:0]  entry_pid = '0;
    logic [LPID_W-1:0] entry_lpid = '0;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic [PID_W-1:0]  req_pid = '0;
    logic [LPID_W-1:0] req_lpid = '0;
    logic              hit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbm_entry_match #(.VPN_W(VPN_W), .PID_W(PID_W), .LPID_W(LPID_W)) dut (
        .clk, .rst_n, .entry_valid, .entry_size, .entry_xbit, .entry_vpn,
        .entry_pid, .entry_lpid, .req_vpn, .req_pid, .req_lpid, .hit
    );

    function automatic logic model(logic v, logic [2:0] s, logic x,
                                   logic [VPN_W-1:0] ev, logic [VPN_W-1:0] rv,
                                   logic [PID_W-1:0] ep, logic [PID_W-1:0] rp,
                                   logic [LPID_W-1:0] el, logic [LPID_W-1:0] rl);
        int sh;
        logic [VPN_W-1:0] lowmask;
        logic up, hok;
        if (s > 3'd5) return 1'b0;
        sh = (s == 3'd5) ? 18 : 4 * int'(s);
        lowmask = (VPN_W'(1) << sh) - VPN_W'(1);
        up  = ((ev >> sh) == (rv >> sh));
        hok = !x || (s == 3'd0) || ((rv & ~ev & lowmask) != '0);
        return v && up && hok && (ep == '0 || ep == rp) && (el == rl);
    endfunction

    task automatic check(string tag, logic exp);
        checks++;
        if (hit !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b size=%0d x=%0b ev=%h rv=%h",
                     tag, hit, exp, entry_size, entry_xbit, entry_vpn, req_vpn);
        end
    endtask

    // Drive at a falling edge, result is registered at the next rising edge,
    // sample at the falling edge after it.
    task automatic run(string tag, logic v, logic [2:0] s, logic x,
                       logic [VPN_W-1:0] ev, logic [VPN_W-1:0] rv,
                       logic [PID_W-1:0] ep, logic [PID_W-1:0] rp,
                       logic [LPID_W-1:0] el, logic [LPID_W-1:0] rl, logic exp);
        entry_valid = v; entry_size = s; entry_xbit = x; entry_vpn = ev;
        req_vpn = rv; entry_pid = ep; req_pid = rp; entry_lpid = el; req_lpid = rl;
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    localparam logic [VPN_W-1:0] BASE = 52'hA5C3E9172B4D6;
    localparam logic [PID_W-1:0] PID0 = 14'h1A3;
    localparam logic [LPID_W-1:0] LP0 = 8'h5C;

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [VPN_W-1:0] ev, rv;
        // R1: reset holds hit low even with matching inputs
        @(negedge clk);
        entry_valid = 1; entry_size = 3'd2; entry_xbit = 0; entry_vpn = BASE;
        req_vpn = BASE; entry_pid = PID0; req_pid = PID0; entry_lpid = LP0; req_lpid = LP0;
        @(negedge clk); check("R1", 1'b0);
        @(negedge clk); check("R1", 1'b0);
        rst_n = 1'b1;
        // R1: latency - miss registered, then switch to hit and look before the edge
        run("R1", 1, 3'd2, 0, BASE, BASE ^ 52'h100, PID0, PID0, LP0, LP0, 1'b0);
        req_vpn = BASE;
        #1 check("R1", 1'b0);
        @(negedge clk); check("R1", 1'b1);

        // R2: invalid entry
        run("R2", 0, 3'd0, 0, BASE, BASE, PID0, PID0, LP0, LP0, 1'b0);
        run("R2", 0, 3'd5, 0, BASE, BASE, 14'h0, PID0, LP0, LP0, 1'b0);

        // R3/R4: every size code, both flag values, each single-bit flip
        for (int s = 0; s < 8; s++) begin
            for (int x = 0; x < 2; x++) begin
                for (int k = 0; k <= VPN_W; k++) begin
                    ev = BASE;
                    rv = (k < VPN_W) ? (BASE ^ (VPN_W'(1) << k)) : BASE;
                    run((s <= 5) ? "R3" : "R4", 1, 3'(s), 1'(x), ev, rv, PID0, PID0, LP0, LP0,
                        model(1, 3'(s), 1'(x), ev, rv, PID0, PID0, LP0, LP0));
                end
            end
        end

        // R5: wildcard and exact process tags
        run("R5", 1, 3'd1, 0, BASE, BASE, 14'h0, 14'h3FFF, LP0, LP0, 1'b1);
        run("R5", 1, 3'd1, 0, BASE, BASE, PID0, PID0, LP0, LP0, 1'b1);
        for (int b = 0; b < PID_W; b++)
            run("R5", 1, 3'd1, 0, BASE, BASE, PID0, PID0 ^ (PID_W'(1) << b), LP0, LP0, 1'b0);
        // R6: partition tags
        for (int b = 0; b < LPID_W; b++)
            run("R6", 1, 3'd3, 0, BASE, BASE, 14'h0, PID0, LP0, LP0 ^ (LPID_W'(1) << b), 1'b0);

        // R8: exclusion flag on a 4 KB page
        run("R8", 1, 3'd0, 1, BASE, BASE, PID0, PID0, LP0, LP0, 1'b1);
        run("R8", 1, 3'd0, 1, {BASE[51:4], 4'h0}, {BASE[51:4], 4'h0}, PID0, PID0, LP0, LP0, 1'b1);

        // R9: 64 KB hole in a 1 MB page, hand-computed
        ev = {BASE[51:8], 8'h0F};
        run("R9", 1, 3'd2, 1, ev, {BASE[51:8], 8'h00}, PID0, PID0, LP0, LP0, 1'b0);
        run("R9", 1, 3'd2, 1, ev, {BASE[51:8], 8'h0F}, PID0, PID0, LP0, LP0, 1'b0);
        run("R9", 1, 3'd2, 1, ev, {BASE[51:8], 8'h10}, PID0, PID0, LP0, LP0, 1'b1);
        run("R9", 1, 3'd2, 1, ev, {BASE[51:8], 8'hFF}, PID0, PID0, LP0, LP0, 1'b1);
        run("R8", 1, 3'd2, 0, ev, {BASE[51:8], 8'h03}, PID0, PID0, LP0, LP0, 1'b1);
        for (int a = 0; a < 256; a++)
            run("R9", 1, 3'd2, 1, ev, {BASE[51:8], 8'(a)}, PID0, PID0, LP0, LP0, (a >= 16));

        // R7: full in-page sweeps against the arithmetic model
        for (int s = 1; s <= 5; s++) begin
            for (int a = 0; a < 256; a++) begin
                ev = {BASE[51:8], 8'h3B};
                rv = {BASE[51:8], 8'(a)} ^ ((s == 5) ? 52'h2A700 : 52'h0);
                run("R7", 1, 3'(s), 1, ev, rv, PID0, PID0, LP0, LP0,
                    model(1, 3'(s), 1, ev, rv, PID0, PID0, LP0, LP0));
            end
        end

        summary();
        $finish;
    end

endmodule